// File: doc/BRIEF.md
# Round-robin interrupt dispatcher

This block sits between a vector of raw interrupt status lines and two processor contexts. Each context owns its own enable mask. The pending set of a context is the raw status gated by that mask. A context serves its pending set one source at a time, and no source outranks another. A per-context search pointer visits one candidate index per clock and moves forward after every probe. Once it finds a pending source, the dispatcher presents that source's number with a valid strobe. It holds the number until the consumer acknowledges it. The next search starts just past the source that was served.

The status vector and the masks are organised as 32-bit words, and the word order is reversed relative to source numbering. When cascading is enabled, a contiguous window of source numbers belongs to external lines. A selection inside that window is renumbered from zero and flagged as external. A single write port enables or disables one source at a time. An enable takes the online state and the affinity of each context into account.

Top module: `rr_irq_dispatch`

## Requirements
- R1: After reset, no context shows a valid selection, all mask bits are zero and both search pointers are zero, so the first search begins at source 0.
- R2: A source is pending for a context only when its raw status bit and that context's mask bit are both 1. Each 32-bit word is gated on its own.
- R3: With W = NSRC/32 words, source n sits in word (n/32) XOR (W-1) at bit n mod 32, and word w occupies bits [32w+31:32w] of the status input. For NSRC = 64, source 3 is status bit 35 and source 33 is status bit 1.
- R4: A write with wr_unmask_i = 1 sets the source's mask bit for every context c whose online_i[c] and aff_i[c] are both 1, and clears it for every other context. A write with wr_unmask_i = 0 clears the bit for all contexts. The write takes effect at the clock edge, so a probe at that same edge still uses the previous mask.
- R5: While a context has no selection and something is pending, it probes exactly one index per clock and advances its pointer by one modulo NSRC after each probe. A search therefore ends within NSRC clocks.
- R6: No source has fixed priority. After serving source s, the next selection is the first pending source in the cyclic order s+1, s+2, and so on.
- R7: While a context has nothing pending, it makes no selection and its pointer does not move.
- R8: A selection stays valid, with its number and flag unchanged, until ack_i for that context is 1 at a clock edge. Valid then drops at that edge, and the search resumes on the following clock.
- R9: With cascading enabled, a selected source s with CASC_LO <= s <= CASC_HI is output as s - CASC_LO with ext_o = 1. Any other source is output as s with ext_o = 0 (defaults CASC_LO = 40, CASC_HI = 45).
- R10: Each context has its own masks, pointer and handshake. Context c uses bit c of vld_o, ext_o and ack_i and bits [c*IW +: IW] of idx_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stat_i | input | NSRC | Raw status, word-reversed layout |
| wr_en_i | input | 1 | Mask write strobe |
| wr_unmask_i | input | 1 | 1 = enable source, 0 = disable for all contexts |
| wr_src_i | input | IW | Source number written |
| online_i | input | NCTX | Context online flags used by an enable |
| aff_i | input | NCTX | Affinity of the written source, per context |
| ack_i | input | NCTX | Per-context acknowledge of the held selection |
| vld_o | output | NCTX | Per-context selection valid |
| idx_o | output | NCTX*IW | Per-context selected number (remapped if external) |
| ext_o | output | NCTX | Per-context external-line flag |

## Verification
A mask write and a probe of the same source can fall on the same clock edge. The bench parks a context's pointer on a source whose mask bit is set while its raw line is low. It then raises the raw line and issues a disable of that source in the same cycle. The selection must appear after exactly one edge, because the probe reads the mask as it stood before the write. After the acknowledge the source must never come back. A second overlap, a disable arriving while that same source is held, is judged by the held number staying put until the acknowledge.

// File: rtl/rrd_pkg.sv
`timescale 1ns/1ps
package rrd_pkg;

    localparam int unsigned WORD_W = 32;

    // Position of source idx inside a word-reversed vector of nw words.
    function automatic int unsigned reg_pos(input int unsigned idx, input int unsigned nw);
        return (((idx / WORD_W) ^ (nw - 1)) * WORD_W) + (idx % WORD_W);
    endfunction

endpackage

// File: rtl/rrd_mask_bank.sv
`timescale 1ns/1ps
module rrd_mask_bank #(
    parameter int unsigned NSRC = 64,
    parameter int unsigned NCTX = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic                       wr_unmask,
    input  logic [$clog2(NSRC)-1:0]    wr_src,
    input  logic [NCTX-1:0]            online,
    input  logic [NCTX-1:0]            aff,
    output logic [NCTX*NSRC-1:0]       mask_o
);
    import rrd_pkg::*;

    localparam int unsigned NW = NSRC / WORD_W;
    localparam int unsigned PW = $clog2(NSRC);

    typedef struct packed {
        logic [NCTX-1:0][NSRC-1:0] m;
    } bank_t;

    bank_t bank_d, bank_q;
    logic [PW-1:0] wpos;

    always_comb begin
        wpos   = PW'(reg_pos(32'(wr_src), NW));
        bank_d = bank_q;
        if (wr_en) begin
            for (int c = 0; c < int'(NCTX); c++) begin
                bank_d.m[c][wpos] = wr_unmask & online[c] & aff[c];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign mask_o = bank_q.m;

endmodule

// File: rtl/rrd_pend_gate.sv
`timescale 1ns/1ps
module rrd_pend_gate #(
    parameter int unsigned NSRC = 64,
    parameter int unsigned NCTX = 2
) (
    input  logic [NSRC-1:0]       stat_i,
    input  logic [NCTX*NSRC-1:0]  mask_i,
    output logic [NCTX*NSRC-1:0]  pend_o
);
    import rrd_pkg::*;

    localparam int unsigned NW = NSRC / WORD_W;

    for (genvar c = 0; c < int'(NCTX); c++) begin : g_ctx
        for (genvar w = 0; w < int'(NW); w++) begin : g_word
            assign pend_o[c*NSRC + w*WORD_W +: WORD_W] =
                stat_i[w*WORD_W +: WORD_W] & mask_i[c*NSRC + w*WORD_W +: WORD_W];
        end
    end

endmodule

// File: rtl/rrd_casc_map.sv
`timescale 1ns/1ps
module rrd_casc_map #(
    parameter int unsigned NSRC    = 64,
    parameter bit          CASC_EN = 1'b1,
    parameter int unsigned CASC_LO = 40,
    parameter int unsigned CASC_HI = 45
) (
    input  logic [$clog2(NSRC)-1:0] src_i,
    output logic [$clog2(NSRC)-1:0] num_o,
    output logic                    ext_o
);
    localparam int unsigned IW = $clog2(NSRC);

    if (CASC_EN) begin : g_casc
        logic in_win;
        assign in_win = (src_i >= IW'(CASC_LO)) && (src_i <= IW'(CASC_HI));
        assign num_o  = in_win ? (src_i - IW'(CASC_LO)) : src_i;
        assign ext_o  = in_win;
    end else begin : g_flat
        assign num_o = src_i;
        assign ext_o = 1'b0;
    end

endmodule

// File: rtl/rrd_scan.sv
`timescale 1ns/1ps
module rrd_scan #(
    parameter int unsigned NSRC    = 64,
    parameter bit          CASC_EN = 1'b1,
    parameter int unsigned CASC_LO = 40,
    parameter int unsigned CASC_HI = 45
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NSRC-1:0]         pend_i,
    input  logic                    ack_i,
    output logic                    vld_o,
    output logic [$clog2(NSRC)-1:0] idx_o,
    output logic                    ext_o
);
    import rrd_pkg::*;

    localparam int unsigned NW = NSRC / WORD_W;
    localparam int unsigned IW = $clog2(NSRC);

    typedef struct packed {
        logic [IW-1:0] ptr;
        logic          vld;
        logic [IW-1:0] idx;
        logic          ext;
    } scan_t;

    scan_t         st_d, st_q;
    logic [IW-1:0] ppos;
    logic          any_pend;
    logic          hit;
    logic [IW-1:0] map_num;
    logic          map_ext;

    rrd_casc_map #(
        .NSRC(NSRC), .CASC_EN(CASC_EN), .CASC_LO(CASC_LO), .CASC_HI(CASC_HI)
    ) u_map (
        .src_i (st_q.ptr),
        .num_o (map_num),
        .ext_o (map_ext)
    );

    always_comb begin
        ppos     = IW'(reg_pos(32'(st_q.ptr), NW));
        any_pend = |pend_i;
        hit      = pend_i[ppos];
        st_d     = st_q;
        if (st_q.vld) begin
            if (ack_i) st_d.vld = 1'b0;
        end else if (any_pend) begin
            // power-of-two source count: the add wraps modulo NSRC
            st_d.ptr = st_q.ptr + 1'b1;
            if (hit) begin
                st_d.vld = 1'b1;
                st_d.idx = map_num;
                st_d.ext = map_ext;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vld_o = st_q.vld;
    assign idx_o = st_q.idx;
    assign ext_o = st_q.ext;

endmodule

// File: rtl/rr_irq_dispatch.sv
`timescale 1ns/1ps
module rr_irq_dispatch #(
    parameter int unsigned NSRC    = 64,
    parameter int unsigned NCTX    = 2,
    parameter bit          CASC_EN = 1'b1,
    parameter int unsigned CASC_LO = 40,
    parameter int unsigned CASC_HI = 45
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NSRC-1:0]              stat_i,
    input  logic                         wr_en_i,
    input  logic                         wr_unmask_i,
    input  logic [$clog2(NSRC)-1:0]      wr_src_i,
    input  logic [NCTX-1:0]              online_i,
    input  logic [NCTX-1:0]              aff_i,
    input  logic [NCTX-1:0]              ack_i,
    output logic [NCTX-1:0]              vld_o,
    output logic [NCTX*$clog2(NSRC)-1:0] idx_o,
    output logic [NCTX-1:0]              ext_o
);
    localparam int unsigned IW = $clog2(NSRC);

    logic [NCTX*NSRC-1:0] mask_w;
    logic [NCTX*NSRC-1:0] pend_w;

    rrd_mask_bank #(.NSRC(NSRC), .NCTX(NCTX)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en_i),
        .wr_unmask (wr_unmask_i),
        .wr_src    (wr_src_i),
        .online    (online_i),
        .aff       (aff_i),
        .mask_o    (mask_w)
    );

    rrd_pend_gate #(.NSRC(NSRC), .NCTX(NCTX)) u_gate (
        .stat_i (stat_i),
        .mask_i (mask_w),
        .pend_o (pend_w)
    );

    for (genvar c = 0; c < int'(NCTX); c++) begin : g_scan
        rrd_scan #(
            .NSRC(NSRC), .CASC_EN(CASC_EN), .CASC_LO(CASC_LO), .CASC_HI(CASC_HI)
        ) u_scan (
            .clk    (clk),
            .rst_n  (rst_n),
            .pend_i (pend_w[c*NSRC +: NSRC]),
            .ack_i  (ack_i[c]),
            .vld_o  (vld_o[c]),
            .idx_o  (idx_o[c*IW +: IW]),
            .ext_o  (ext_o[c])
        );
    end

endmodule

// File: rtl/rrd_checker.sv
`timescale 1ns/1ps
module rrd_checker #(
    parameter int unsigned NSRC    = 64,
    parameter int unsigned NCTX    = 2,
    parameter bit          CASC_EN = 1'b1,
    parameter int unsigned CASC_LO = 40,
    parameter int unsigned CASC_HI = 45
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         wr_en_i,
    input logic                         wr_unmask_i,
    input logic [$clog2(NSRC)-1:0]      wr_src_i,
    input logic [NCTX-1:0]              online_i,
    input logic [NCTX-1:0]              aff_i,
    input logic [NCTX-1:0]              ack_i,
    input logic [NCTX-1:0]              vld_o,
    input logic [NCTX*$clog2(NSRC)-1:0] idx_o,
    input logic [NCTX-1:0]              ext_o,
    input logic [NCTX*NSRC-1:0]         mask_w,
    input logic [NCTX*NSRC-1:0]         pend_w
);
    import rrd_pkg::*;

    localparam int unsigned IW = $clog2(NSRC);
    localparam int unsigned NW = NSRC / WORD_W;

    logic [IW-1:0] wpos;
    assign wpos = IW'(reg_pos(32'(wr_src_i), NW));

    for (genvar c = 0; c < int'(NCTX); c++) begin : g_chk
        // R8: held selection is frozen until acknowledged
        a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
            vld_o[c] && !ack_i[c] |=> vld_o[c] && $stable(idx_o[c*IW +: IW]) && $stable(ext_o[c]));

        // R8: acknowledge drops valid at that edge
        a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
            vld_o[c] && ack_i[c] |=> !vld_o[c]);

        // R7: no selection appears out of an empty pending set
        a_r7_idle: assert property (@(posedge clk) disable iff (!rst_n)
            !vld_o[c] && (pend_w[c*NSRC +: NSRC] == '0) |=> !vld_o[c]);

        // R4: a disable write leaves the bit clear in every context
        a_r4_mask_clear: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en_i && !wr_unmask_i |=> !mask_w[c*NSRC + int'($past(wpos))]);

        // R4: an enable lands only where the context is online and allowed
        a_r4_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en_i && wr_unmask_i |=>
                mask_w[c*NSRC + int'($past(wpos))] == $past(online_i[c] && aff_i[c]));

        if (CASC_EN) begin : g_ext
            // R9: external numbers stay inside the window width
            a_r9_ext_range: assert property (@(posedge clk) disable iff (!rst_n)
                vld_o[c] && ext_o[c] |-> idx_o[c*IW +: IW] <= IW'(CASC_HI - CASC_LO));
        end else begin : g_noext
            a_r9_no_ext: assert property (@(posedge clk) disable iff (!rst_n)
                vld_o[c] |-> !ext_o[c]);
        end
    end

endmodule

bind rr_irq_dispatch rrd_checker #(
    .NSRC(NSRC), .NCTX(NCTX), .CASC_EN(CASC_EN), .CASC_LO(CASC_LO), .CASC_HI(CASC_HI)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en_i     (wr_en_i),
    .wr_unmask_i (wr_unmask_i),
    .wr_src_i    (wr_src_i),
    .online_i    (online_i),
    .aff_i       (aff_i),
    .ack_i       (ack_i),
    .vld_o       (vld_o),
    .idx_o       (idx_o),
    .ext_o       (ext_o),
    .mask_w      (mask_w),
    .pend_w      (pend_w)
);

// File: tb/rr_irq_dispatch_test.sv
`timescale 1ns/1ps
module rr_irq_dispatch_test;

    localparam int N  = 64;
    localparam int IW = 6;
    localparam int LO = 40;
    localparam int HI = 45;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   stat = '0;
    logic           wr_en = 1'b0;
    logic           wr_unmask = 1'b0;
    logic [IW-1:0]  wr_src = '0;
    logic [1:0]     online = 2'b11;
    logic [1:0]     aff = 2'b00;
    logic [1:0]     ack = 2'b00;
    logic [1:0]     vld;
    logic [2*IW-1:0] idx;
    logic [1:0]     ext;

    int n_run  = 0;
    int n_fail = 0;
    int last_rr = 0;
    int a_src = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rr_irq_dispatch #(.NSRC(N), .NCTX(2), .CASC_EN(1'b1), .CASC_LO(LO), .CASC_HI(HI)) uut (
        .clk(clk), .rst_n(rst_n), .stat_i(stat), .wr_en_i(wr_en), .wr_unmask_i(wr_unmask),
        .wr_src_i(wr_src), .online_i(online), .aff_i(aff), .ack_i(ack),
        .vld_o(vld), .idx_o(idx), .ext_o(ext)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // R3: word-reversed placement of source n
    task automatic set_raw(input int n, input bit v);
        stat[((n / 32) ^ 1) * 32 + (n % 32)] = v;
    endtask

    task automatic wr(input bit en, input int src, input logic [1:0] onl, input logic [1:0] af);
        wr_en = 1'b1; wr_unmask = en; wr_src = IW'(src); online = onl; aff = af;
        step();
        wr_en = 1'b0;
    endtask

    task automatic do_ack(input int c);
        ack[c] = 1'b1;
        step();
        ack[c] = 1'b0;
    endtask

    task automatic wait_vld(input int c, input int lim, output int edges);
        edges = 0;
        while (!vld[c] && edges < lim) begin
            step();
            edges++;
        end
    endtask

    function automatic int cur_idx(input int c);
        return int'(idx[c*IW +: IW]);
    endfunction

    // R9: expected number and flag
    task automatic exp_out(input int s, output int num, output bit ex);
        if (s >= LO && s <= HI) begin num = s - LO; ex = 1'b1; end
        else begin num = s; ex = 1'b0; end
    endtask

    task automatic t_reset();
        int e;
        chk(vld == 2'b00, "R1", "valid after reset", int'(vld), 0);
        stat = '1;
        repeat (5) step();
        chk(vld == 2'b00, "R2", "all raw set but masks zero", int'(vld), 0);
        stat = '0;
        wr(1'b1, 0, 2'b11, 2'b01);
        wr(1'b1, 63, 2'b11, 2'b01);
        set_raw(0, 1'b1); set_raw(63, 1'b1);
        wait_vld(0, N + 2, e);
        chk(e == 1, "R1", "edges to first hit from pointer zero", e, 1);
        chk(cur_idx(0) == 0, "R1", "first served source", cur_idx(0), 0);
        stat = '0;
        do_ack(0);
        wr(1'b0, 0, 2'b11, 2'b11);
        wr(1'b0, 63, 2'b11, 2'b11);
    endtask

    task automatic t_word_order();
        int e;
        wr(1'b1, 3, 2'b11, 2'b01);
        wr(1'b1, 33, 2'b11, 2'b01);
        stat = '0; stat[35] = 1'b1;
        wait_vld(0, N + 2, e);
        chk(vld[0] && cur_idx(0) == 3, "R3", "status bit 35 serves source", cur_idx(0), 3);
        stat = '0; do_ack(0);
        stat[1] = 1'b1;
        wait_vld(0, N + 2, e);
        chk(vld[0] && cur_idx(0) == 33, "R3", "status bit 1 serves source", cur_idx(0), 33);
        stat = '0; do_ack(0);
        stat[3] = 1'b1;
        repeat (N + 6) step();
        chk(!vld[0], "R3", "status bit 3 is masked source 35", int'(vld[0]), 0);
        stat = '0;
        wr(1'b0, 3, 2'b11, 2'b11);
        wr(1'b0, 33, 2'b11, 2'b11);
    endtask

    function automatic int next_after(input int prev);
        for (int j = 1; j <= N; j++) begin
            int cand = (prev + j) % N;
            if (cand == 2 || cand == 10 || cand == 20) return cand;
        end
        return -1;
    endfunction

    task automatic t_round_robin();
        int e;
        int prev = -1;
        wr(1'b1, 2, 2'b11, 2'b01);
        wr(1'b1, 10, 2'b11, 2'b01);
        wr(1'b1, 20, 2'b11, 2'b01);
        set_raw(2, 1'b1); set_raw(10, 1'b1); set_raw(20, 1'b1);
        for (int k = 0; k < 6; k++) begin
            wait_vld(0, N + 2, e);
            chk(vld[0] && e <= N, "R5", "search ends within source count", e, N);
            if (k > 0)
                chk(cur_idx(0) == next_after(prev), "R6", "cyclic successor", cur_idx(0), next_after(prev));
            if (k == 1) begin
                int held = cur_idx(0);
                repeat (8) step();
                chk(vld[0] && cur_idx(0) == held, "R8", "held without ack", cur_idx(0), held);
            end
            prev = cur_idx(0);
            if (k == 5) stat = '0;
            do_ack(0);
            chk(!vld[0], "R8", "valid drops after ack", int'(vld[0]), 0);
        end
        last_rr = prev;
        wr(1'b0, 2, 2'b11, 2'b11);
        wr(1'b0, 10, 2'b11, 2'b11);
        wr(1'b0, 20, 2'b11, 2'b11);
    endtask

    task automatic t_idle();
        int e, num;
        bit ex;
        int b;
        repeat (100) step();
        chk(!vld[0], "R7", "no selection while idle", int'(vld[0]), 0);
        a_src = (last_rr + 30) % N;
        b     = (last_rr + 50) % N;
        wr(1'b1, a_src, 2'b11, 2'b01);
        wr(1'b1, b, 2'b11, 2'b01);
        set_raw(a_src, 1'b1); set_raw(b, 1'b1);
        wait_vld(0, N + 2, e);
        exp_out(a_src, num, ex);
        chk(vld[0] && cur_idx(0) == num && ext[0] == ex, "R7", "pointer held during idle", cur_idx(0), num);
        chk(e == 30, "R5", "one probe per clock", e, 30);
        stat = '0;
        do_ack(0);
        wr(1'b0, a_src, 2'b11, 2'b11);
        wr(1'b0, b, 2'b11, 2'b11);
    endtask

    task automatic t_same_cycle();
        int t, num;
        bit ex;
        t = (a_src + 1) % N;
        wr(1'b1, t, 2'b11, 2'b01);
        set_raw(t, 1'b1);
        wr(1'b0, t, 2'b11, 2'b11);
        exp_out(t, num, ex);
        chk(vld[0] && cur_idx(0) == num, "R4", "probe uses mask before same-edge write", cur_idx(0), num);
        set_raw(63, 1'b0);
        do_ack(0);
        repeat (N + 6) step();
        chk(!vld[0], "R4", "disabled source not served again", int'(vld[0]), 0);
        stat = '0;
    endtask

    task automatic t_cascade();
        int e, num;
        bit ex;
        int srcs[4] = '{40, 45, 46, 39};
        foreach (srcs[i]) wr(1'b1, srcs[i], 2'b11, 2'b10);
        foreach (srcs[i]) begin
            stat = '0;
            set_raw(srcs[i], 1'b1);
            wait_vld(1, N + 2, e);
            exp_out(srcs[i], num, ex);
            chk(vld[1] && cur_idx(1) == num, "R9", "remapped number", cur_idx(1), num);
            chk(ext[1] == ex, "R9", "external flag", int'(ext[1]), int'(ex));
            chk(!vld[0], "R10", "other context untouched", int'(vld[0]), 0);
            stat = '0;
            do_ack(1);
        end
    endtask

    task automatic t_mask_all();
        int e;
        wr(1'b1, 50, 2'b11, 2'b11);
        set_raw(50, 1'b1);
        wait_vld(0, N + 2, e);
        wait_vld(1, N + 2, e);
        chk(vld[0] && cur_idx(0) == 50, "R10", "context 0 serves shared source", cur_idx(0), 50);
        chk(vld[1] && cur_idx(1) == 50, "R10", "context 1 serves shared source", cur_idx(1), 50);
        wr(1'b0, 50, 2'b11, 2'b11);
        chk(vld[0] && cur_idx(0) == 50, "R8", "held through disable write", cur_idx(0), 50);
        ack = 2'b11; step(); ack = 2'b00;
        repeat (2 * N + 2) step();
        chk(vld == 2'b00, "R4", "disable clears every context", int'(vld), 0);
        stat = '0;
    endtask

    task automatic t_offline();
        bit seen0 = 1'b0;
        bit seen1 = 1'b0;
        int got0 = -1;
        wr(1'b1, 7, 2'b11, 2'b11);
        wr(1'b1, 7, 2'b01, 2'b11);
        set_raw(7, 1'b1);
        for (int k = 0; k < 2 * N + 2; k++) begin
            step();
            if (vld[0] && !seen0) begin seen0 = 1'b1; got0 = cur_idx(0); end
            if (vld[1]) seen1 = 1'b1;
        end
        chk(seen0 && got0 == 7, "R4", "online context enabled", got0, 7);
        chk(!seen1, "R4", "offline context bit cleared", int'(seen1), 0);
        stat = '0;
        if (vld[0]) do_ack(0);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_word_order();
        t_round_robin();
        t_idle();
        t_same_cycle();
        t_cascade();
        t_mask_all();
        t_offline();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual 0 expected 1");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule